// File: doc/BRIEF.md
# Segmented Memory Protection Unit

The unit sits beside the CPU bus in front of a nonvolatile memory window that spans byte addresses 0x04400 through 0x13FFF. Two programmable borders split this window into three segments. Each segment has its own read, write and execute permission bits. Every bus access that lands in the window is checked against the permission that matches its kind. A write that is refused is held back from the memory array in the same cycle.

A violation is reported in one of two ways, chosen per segment. The first is a sticky flag that feeds a non-maskable interrupt request. The second is a one-cycle reset request. Configuration writes are guarded by a key byte. Setting the lock together with the enable freezes the configuration until the next brown-out reset, which is `rst_ni`.

Register map, selected by `reg_addr_i`:
- 0: control
- 1: flags
- 2: border 1
- 3: border 2
- 4: permissions

Top module: `seg_guard`

## Requirements
- R1: After reset, control reads 0x0000, flags 0x0000, both borders 0x0440, permissions 0x0777. `nmi_req_o`, `rst_req_o` are low and `wr_qual_o` is low with no access.
- R2: A border register value V places the border at byte address V*16. Inside the window, an address below border 1 belongs to segment 1 (flag bit 0). Otherwise an address below border 2 belongs to segment 2 (flag bit 1). Any remaining address belongs to segment 3 (flag bit 2).
- R3: A control write (address 0) takes effect only when bits 15:8 equal 0xA5, and such a write opens configuration access. A control write with any other upper byte leaves control unchanged and closes access. Border and permission writes are ignored while access is closed.
- R4: Control bit 0 enables checking. While it is clear, or when the address lies outside 0x04400..0x13FFF, no access is refused, no flag is set and no reset is requested.
- R5: Permission nibble s (bits 4s+3:4s, s=0..2 for segments 1..3) holds read in bit 0, write in bit 1, execute in bit 2 and violation select in bit 3. Access kind 0 is checked against read, kind 1 against write and kind 2 against execute. Kind 3 is never checked.
- R6: A refused access to a segment whose select bit is 0 sets that segment's flag on the next clock edge. `nmi_req_o` is high whenever control bit 4 is set and any flag is set.
- R7: A refused access to a segment whose select bit is 1 raises `rst_req_o` for the following cycle and sets no flag.
- R8: `wr_qual_o` is high exactly when a kind-1 access is valid and not refused, in the same cycle as the access.
- R9: Writing the flags register clears each flag whose written bit is 0. This write needs neither the key nor an unlocked state.
- R10: Once control bits 0 and 1 are both set, control, border and permission writes are ignored until reset.
- R11: With borders 0x0600/0x0800 and segment 2 write-protected, a write to 0x06002 sets flag bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous brown-out reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| acc_valid_i | input | 1 | CPU access present this cycle |
| acc_kind_i | input | 2 | 0 read, 1 write, 2 fetch, 3 none |
| acc_addr_i | input | 20 | CPU byte address |
| wr_qual_o | output | 1 | Write allowed to reach memory |
| nmi_req_o | output | 1 | Non-maskable interrupt request |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The assertions assume that a CPU access and its kind are steady across a clock cycle. They also assume that `acc_kind_i` is driven to a known value whenever `acc_valid_i` is high. The stimulus changes every input only just after a rising edge and holds it until the next edge. It drops `acc_valid_i` between accesses, so each flag, reset pulse and write qualification can be traced to a single access. Permission, border and select values are always loaded through the keyed register path, never forced.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  localparam int NSEG = 3;

  typedef enum logic [1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_EX   = 2'd2,
    ACC_NONE = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_FLAG = 3'd1,
    RA_BRD1 = 3'd2,
    RA_BRD2 = 3'd3,
    RA_PERM = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic vsel;
    logic ex;
    logic wr;
    logic rd;
  } seg_perm_t;
endpackage

// File: rtl/sg_regs.sv
module sg_regs
  import seg_guard_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter logic [7:0]  KEY    = 8'hA5,
  parameter logic [15:0] BRD_RST = 16'h0440
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [2:0]               addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NSEG-1:0]          flag_set_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     en_o,
  output logic                     ie_o,
  output logic                     locked_o,
  output logic [DATA_W-1:0]        brd1_o,
  output logic [DATA_W-1:0]        brd2_o,
  output seg_perm_t [NSEG-1:0]     perm_o,
  output logic [NSEG-1:0]          flags_o
);
  localparam int PW = $bits(seg_perm_t);

  logic en_q, lock_q, ie_q, open_q;
  logic [DATA_W-1:0] brd1_q, brd2_q;
  seg_perm_t [NSEG-1:0] perm_q;
  logic [NSEG-1:0] flags_q, flags_d;

  logic key_ok, ctrl_wr, cfg_ok;

  assign key_ok   = wdata_i[DATA_W-1 -: 8] == KEY;
  assign ctrl_wr  = we_i && (addr_i == RA_CTRL);
  assign locked_o = en_q && lock_q;
  assign cfg_ok   = open_q && !locked_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      ie_q   <= 1'b0;
      open_q <= 1'b0;
    end else if (ctrl_wr && !locked_o) begin
      open_q <= key_ok;
      if (key_ok) begin
        en_q   <= wdata_i[0];
        lock_q <= wdata_i[1];
        ie_q   <= wdata_i[4];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brd1_q <= BRD_RST;
      brd2_q <= BRD_RST;
    end else if (we_i && cfg_ok) begin
      if (addr_i == RA_BRD1) brd1_q <= wdata_i;
      if (addr_i == RA_BRD2) brd2_q <= wdata_i;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_perm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) perm_q[s] <= '{vsel: 1'b0, ex: 1'b1, wr: 1'b1, rd: 1'b1};
      else if (we_i && cfg_ok && addr_i == RA_PERM) perm_q[s] <= wdata_i[PW*s +: PW];
    end
  end

  // set wins over a clear in the same cycle
  always_comb begin
    flags_d = flags_q;
    if (we_i && addr_i == RA_FLAG) flags_d = flags_d & wdata_i[NSEG-1:0];
    flags_d = flags_d | flag_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  always_comb begin
    case (addr_i)
      RA_CTRL: rdata_o = DATA_W'({ie_q, 2'b00, lock_q, en_q});
      RA_FLAG: rdata_o = DATA_W'(flags_q);
      RA_BRD1: rdata_o = brd1_q;
      RA_BRD2: rdata_o = brd2_q;
      RA_PERM: rdata_o = DATA_W'(perm_q);
      default: rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign ie_o    = ie_q;
  assign brd1_o  = brd1_q;
  assign brd2_o  = brd2_q;
  assign perm_o  = perm_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/sg_decode.sv
module sg_decode
  import seg_guard_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                BRD_W     = 16,
  parameter int                GRAN_LOG2 = 4,
  parameter logic [ADDR_W-1:0] REGION_LO = 20'h04400,
  parameter logic [ADDR_W-1:0] REGION_HI = 20'h13FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BRD_W-1:0]  brd1_i,
  input  logic [BRD_W-1:0]  brd2_i,
  output logic              in_region_o,
  output logic [NSEG-1:0]   seg_hit_o
);
  localparam int FULL_W = BRD_W + GRAN_LOG2;

  logic [ADDR_W-1:0] b1_addr, b2_addr;

  assign b1_addr = ADDR_W'({brd1_i, {GRAN_LOG2{1'b0}}});
  assign b2_addr = ADDR_W'({brd2_i, {GRAN_LOG2{1'b0}}});

  assign in_region_o = (addr_i >= REGION_LO) && (addr_i <= REGION_HI);

  // priority: below border 1, then below border 2, else last segment
  always_comb begin
    seg_hit_o = '0;
    if (addr_i < b1_addr)      seg_hit_o[0] = 1'b1;
    else if (addr_i < b2_addr) seg_hit_o[1] = 1'b1;
    else                       seg_hit_o[NSEG-1] = 1'b1;
  end

  if (FULL_W < ADDR_W) begin : g_narrow_warn
    initial $display("sg_decode: border range narrower than address");
  end
endmodule

// File: rtl/sg_check.sv
module sg_check
  import seg_guard_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           kind_i,
  input  logic                 in_region_i,
  input  logic [NSEG-1:0]      seg_hit_i,
  input  seg_perm_t [NSEG-1:0] perm_i,
  input  logic                 en_i,
  input  logic                 ie_i,
  input  logic [NSEG-1:0]      flags_i,
  output logic                 wr_qual_o,
  output logic [NSEG-1:0]      flag_set_o,
  output logic                 rst_req_o,
  output logic                 nmi_req_o
);
  logic [NSEG-1:0] allow, hit_viol, vsel;
  logic viol, rst_q;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_comb begin
      case (kind_i)
        ACC_RD:  allow[s] = perm_i[s].rd;
        ACC_WR:  allow[s] = perm_i[s].wr;
        ACC_EX:  allow[s] = perm_i[s].ex;
        default: allow[s] = 1'b1;
      endcase
    end
    assign hit_viol[s] = seg_hit_i[s] && !allow[s];
    assign vsel[s]     = perm_i[s].vsel;
  end

  assign viol       = en_i && valid_i && in_region_i && |hit_viol;
  assign flag_set_o = viol ? (hit_viol & ~vsel) : '0;
  assign wr_qual_o  = valid_i && (kind_i == ACC_WR) && !viol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= viol && |(hit_viol & vsel);
  end

  assign rst_req_o = rst_q;
  assign nmi_req_o = ie_i && |flags_i;
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 16,
  parameter logic [7:0]        KEY       = 8'hA5,
  parameter logic [ADDR_W-1:0] REGION_LO = 20'h04400,
  parameter logic [ADDR_W-1:0] REGION_HI = 20'h13FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [1:0]        acc_kind_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              wr_qual_o,
  output logic              nmi_req_o,
  output logic              rst_req_o
);
  logic en, ie, locked, in_region;
  logic [DATA_W-1:0] brd1, brd2;
  seg_perm_t [NSEG-1:0] perm;
  logic [NSEG-1:0] flags, flag_set, seg_hit;

  sg_regs #(.DATA_W(DATA_W), .KEY(KEY)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_set_i(flag_set), .rdata_o(reg_rdata_o),
    .en_o(en), .ie_o(ie), .locked_o(locked),
    .brd1_o(brd1), .brd2_o(brd2), .perm_o(perm), .flags_o(flags)
  );

  sg_decode #(
    .ADDR_W(ADDR_W), .BRD_W(DATA_W),
    .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)
  ) i_decode (
    .addr_i(acc_addr_i), .brd1_i(brd1), .brd2_i(brd2),
    .in_region_o(in_region), .seg_hit_o(seg_hit)
  );

  sg_check i_check (
    .clk_i, .rst_ni,
    .valid_i(acc_valid_i), .kind_i(acc_kind_i),
    .in_region_i(in_region), .seg_hit_i(seg_hit), .perm_i(perm),
    .en_i(en), .ie_i(ie), .flags_i(flags),
    .wr_qual_o, .flag_set_o(flag_set), .rst_req_o, .nmi_req_o
  );
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int NSEG   = 3,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [1:0]        acc_kind_i,
  input logic              wr_qual_o,
  input logic              rst_req_o,
  input logic              en,
  input logic              locked,
  input logic [NSEG-1:0]   flags,
  input logic [DATA_W-1:0] brd1,
  input logic [DATA_W-1:0] brd2,
  input logic [4*NSEG-1:0] perm
);
  // R8
  wr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_qual_o |-> acc_valid_i && acc_kind_i == 2'd1);

  // R6
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags & ~$past(flags))) |-> $past(acc_valid_i && en));

  // R7
  rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(acc_valid_i && en));

  // R4
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !rst_req_o);

  // R10
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> locked);

  // R10
  lock_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(brd1) && $stable(brd2) && $stable(perm));
endmodule

bind seg_guard seg_guard_chk #(.NSEG(seg_guard_pkg::NSEG), .DATA_W(DATA_W)) i_seg_guard_chk (
  .clk_i, .rst_ni, .acc_valid_i, .acc_kind_i, .wr_qual_o, .rst_req_o,
  .en, .locked, .flags, .brd1, .brd2, .perm
);

// File: tb/test_seg_guard.sv
module test_seg_guard;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [19:0] acc_addr = '0;
  logic        wr_qual, nmi_req, rst_req;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  seg_guard i_seg_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .acc_valid_i(acc_valid), .acc_kind_i(acc_kind), .acc_addr_i(acc_addr),
    .wr_qual_o(wr_qual), .nmi_req_o(nmi_req), .rst_req_o(rst_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] exp, string req);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  function automatic logic [19:0] pick_addr(int i);
    case (i)
      0: return 20'h043FF;
      1: return 20'h04400;
      2: return 20'h05FFF;
      3: return 20'h06000;
      4: return 20'h07FFF;
      5: return 20'h08000;
      6: return 20'h13FFF;
      default: return 20'h14000;
    endcase
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(3'd0, 16'h0000, "R1 ctrl");
    rd(3'd1, 16'h0000, "R1 flags");
    rd(3'd2, 16'h0440, "R1 brd1");
    rd(3'd3, 16'h0440, "R1 brd2");
    rd(3'd4, 16'h0777, "R1 perm");
    check("R1 nmi", nmi_req, 0);
    check("R1 rst", rst_req, 0);
    check("R1 wrq", wr_qual, 0);

    // R3 closed access ignores border writes
    wr(3'd2, 16'h0600);
    rd(3'd2, 16'h0440, "R3 closed brd1");
    // R3 open with key, configure
    wr(3'd0, 16'hA500);
    wr(3'd2, 16'h0600);
    wr(3'd3, 16'h0800);
    wr(3'd4, 16'h0757);
    rd(3'd2, 16'h0600, "R3 brd1 open");
    rd(3'd3, 16'h0800, "R3 brd2 open");
    rd(3'd4, 16'h0757, "R3 perm open");

    // R4 disabled: write to protected seg passes, no flag
    acc_valid = 1; acc_kind = 2'd1; acc_addr = 20'h06002;
    #1 check("R4 disabled wrq", wr_qual, 1);
    tick(); acc_valid = 0;
    rd(3'd1, 16'h0000, "R4 disabled flags");

    // R6 ie clear: flag set, no nmi
    wr(3'd0, 16'hA501);
    acc_valid = 1; acc_kind = 2'd1; acc_addr = 20'h06002;
    #1 check("R8 blocked wrq", wr_qual, 0);
    tick(); acc_valid = 0;
    rd(3'd1, 16'h0002, "R6 flag ie0");
    check("R6 nmi ie0", nmi_req, 0);
    // R6 enabling interrupt exposes pending flag
    wr(3'd0, 16'hA511);
    check("R6 nmi ie1", nmi_req, 1);
    // R9 clear by writing zero
    wr(3'd1, 16'h0000);
    rd(3'd1, 16'h0000, "R9 clear");
    check("R9 nmi drop", nmi_req, 0);

    // R11 example case
    acc_valid = 1; acc_kind = 2'd1; acc_addr = 20'h06002;
    #1 check("R11 wrq", wr_qual, 0);
    tick(); acc_valid = 0;
    rd(3'd1, 16'h0002, "R11 seg2 flag");
    check("R11 nmi", nmi_req, 1);
    wr(3'd1, 16'h0000);

    // R2 R5 R6 R8 sweep over permission patterns, boundary addresses, kinds
    for (int p = 0; p < 8; p++) begin
      logic [15:0] pw;
      pw = '0;
      for (int s = 0; s < 3; s++) pw[4*s +: 3] = 3'((p + 3*s) & 7);
      wr(3'd4, pw);
      for (int ai = 0; ai < 8; ai++) begin
        for (int k = 0; k < 3; k++) begin
          logic [19:0] a;
          int seg;
          bit inreg, allowed, viol;
          a = pick_addr(ai);
          inreg = (a >= 20'h04400) && (a <= 20'h13FFF);
          seg = (a < 20'h06000) ? 0 : (a < 20'h08000) ? 1 : 2;
          allowed = pw[4*seg + k];
          viol = inreg && !allowed;
          acc_valid = 1; acc_kind = 2'(k); acc_addr = a;
          #1 check("R8 sweep wrq", wr_qual, (k == 1) && !viol);
          tick(); acc_valid = 0;
          rd(3'd1, viol ? 16'(1 << seg) : 16'h0, "R2 R5 sweep flag");
          check("R6 sweep nmi", nmi_req, viol);
          check("R7 sweep rst", rst_req, 0);
          if (viol) wr(3'd1, 16'h0000);
        end
      end
    end

    // R5 kind 3 never checked
    wr(3'd4, 16'h0000);
    acc_valid = 1; acc_kind = 2'd3; acc_addr = 20'h05000;
    tick(); acc_valid = 0;
    rd(3'd1, 16'h0000, "R5 kind3");

    // R7 select reset on segment 3
    wr(3'd4, 16'h0D77);
    acc_valid = 1; acc_kind = 2'd1; acc_addr = 20'h09000;
    #1 check("R8 rst-path wrq", wr_qual, 0);
    tick(); acc_valid = 0;
    check("R7 rst pulse", rst_req, 1);
    rd(3'd1, 16'h0000, "R7 no flag");
    tick();
    check("R7 rst end", rst_req, 0);

    // R3 non-key ctrl write closes and is ignored
    wr(3'd0, 16'h0000);
    rd(3'd0, 16'h0011, "R3 ctrl unchanged");
    wr(3'd2, 16'h0700);
    rd(3'd2, 16'h0600, "R3 closed again");

    // R10 lock
    wr(3'd0, 16'hA513);
    rd(3'd0, 16'h0013, "R10 locked ctrl");
    wr(3'd0, 16'hA500);
    rd(3'd0, 16'h0013, "R10 ctrl frozen");
    wr(3'd4, 16'h0777);
    rd(3'd4, 16'h0D77, "R10 perm frozen");
    wr(3'd3, 16'h0900);
    rd(3'd3, 16'h0800, "R10 brd2 frozen");
    // R9 flags still clearable while locked
    acc_valid = 1; acc_kind = 2'd1; acc_addr = 20'h06002;
    wr(3'd1, 16'h0000);
    acc_valid = 0;
    rd(3'd1, 16'h0000, "R9 set wins? no, seg2 writable now");
    wr(3'd4, 16'h0000);
    acc_valid = 1; acc_kind = 2'd0; acc_addr = 20'h05000;
    tick(); acc_valid = 0;
    rd(3'd1, 16'h0000, "R10 perm still frozen");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule